// File: doc/BRIEF.md
# Shift-Add Sigmoid Pipeline

This block evaluates the logistic sigmoid of a signed 16-bit fixed-point operand using only adders and shifters, and produces one result on every clock cycle. It relies on the identity sigmoid(x) = 1/2 + tanh(x/2)/2. The operand is first clamped to the interval [-1, +1] and halved. A pipelined hyperbolic rotation engine then turns the half-angle into a scaled cosh/sinh pair. A pipelined linear vectoring engine divides sinh by cosh to form tanh. The rotation gain is the same in numerator and denominator, so it cancels in the division and no gain correction multiplier is needed.

A neural-network datapath feeds one operand per cycle with a valid flag. The matching result appears a fixed number of cycles later with its own valid flag. Bubbles in the input stream are kept in the output stream. The result is an unsigned fraction in Q0.16: the code value divided by 65536.

Top module: `sigmoid_cordic`

## Requirements
- R1: While reset is asserted, and until the first accepted operand has crossed the pipeline, out_valid is 0 and out_data is 0.
- R2: With default parameters, out_valid equals in_valid from exactly 42 clock cycles earlier. The block accepts an operand on every cycle, and results keep input order and the input gaps.
- R3: in_data is signed two's complement with 14 fractional bits (16384 represents 1.0). For an operand x within [-1, +1], out_data differs by at most 2 from round(65536 * 1/(1+e^-x)).
- R4: An in_data above 16384 yields the same out_data as 16384. An in_data below -16384 yields the same out_data as -16384.
- R5: An in_data of 0 yields out_data of exactly 32768 (one half).
- R6: For an increasing sequence of operands in [-1, +1], the out_data sequence never decreases.
- R7: Every valid out_data lies in the range 17620 to 47915, and the output mapping never wraps past 16 bits.
- R8: Over a uniform sweep of the range [-1, +1], the mean absolute error of out_data/65536 against the exact sigmoid is no larger than 4.23e-4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand qualifier |
| in_data | input | 16 | Signed operand with 14 fractional bits, nominal range [-1, +1] |
| out_valid | output | 1 | Result qualifier |
| out_data | output | 16 | Unsigned sigmoid value with 16 fractional bits |

## Verification
The embedded assertions track the following on every cycle:
- the valid flag moving one stage per clock through each engine;
- the clamped half-angle staying within one half;
- cosh dominating sinh;
- the residual angle and the residual remainder shrinking to a few LSBs;
- the quotient staying strictly inside (-1, 1);
- the final code staying in range without wrapping.

Only the bench scenarios can show how results relate to inputs. That covers the accuracy against a real-valued sigmoid, the exact one-half at zero, the equality of clamped and boundary operands, monotonic outputs along a sweep, and the mean error over the whole range.

// File: rtl/sig_pkg.sv
package sig_pkg;
  localparam int IN_W    = 16;
  localparam int IN_FRAC = 14;
  localparam int OUT_W   = 16;
  localparam int FR      = 24;
  localparam int DW      = FR + 4;

  typedef logic signed [DW-1:0] word_t;
  typedef struct packed {
    word_t x;
    word_t y;
    word_t z;
  } vec_t;

  // shift amount used by rotation stage s; iterations 4, 13, 40 run twice
  function automatic int hyp_iter(int s);
    int  i;
    int  rep;
    bit  again;
    i = 1; rep = 4; again = 1'b0;
    for (int k = 0; k < s; k++) begin
      if (i == rep && !again) again = 1'b1;
      else begin
        if (i == rep) rep = 3 * rep + 1;
        again = 1'b0;
        i++;
      end
    end
    return i;
  endfunction

  function automatic int hyp_stages(int n);
    return n + ((n >= 4) ? 1 : 0) + ((n >= 13) ? 1 : 0) + ((n >= 40) ? 1 : 0);
  endfunction

  function automatic word_t atanh_q(int i);
    real t;
    real a;
    t = 2.0 ** (-i);
    a = 0.5 * $ln((1.0 + t) / (1.0 - t));
    return word_t'($rtoi(a * (2.0 ** FR) + 0.5));
  endfunction
endpackage

// File: rtl/sig_in_stage.sv
module sig_in_stage
  import sig_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic signed [IN_W-1:0] in_data,
  output logic                   v_o,
  output vec_t                   vec_o
);
  localparam logic signed [IN_W-1:0] ONE = IN_W'(1) << IN_FRAC;
  localparam int    ZSH  = FR - IN_FRAC - 1;
  localparam word_t ZMAX = word_t'(1) <<< (FR - 1);

  logic signed [IN_W-1:0] sat;
  vec_t nxt;
  logic v_q;
  vec_t vec_q;

  always_comb begin
    if (in_data > ONE)       sat = ONE;
    else if (in_data < -ONE) sat = -ONE;
    else                     sat = in_data;
    nxt.x = word_t'(1) <<< FR;
    nxt.y = '0;
    nxt.z = word_t'(sat) <<< ZSH;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) vec_q <= nxt;
  end

  assign v_o   = v_q;
  assign vec_o = vec_q;

  // R4
  sat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_q |-> (vec_q.z <= ZMAX && vec_q.z >= -ZMAX));
endmodule

// File: rtl/sig_hyp_rot.sv
module sig_hyp_rot
  import sig_pkg::*;
#(
  parameter int N_ITER = 18
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  v_i,
  input  vec_t  vec_i,
  output logic  v_o,
  output word_t ch_o,
  output word_t sh_o
);
  localparam int    NS    = hyp_stages(N_ITER);
  localparam word_t ZRESB = word_t'(1) <<< (FR - N_ITER + 1);

  logic v   [0:NS];
  vec_t vec [0:NS];

  assign v[0]   = v_i;
  assign vec[0] = vec_i;

  for (genvar s = 0; s < NS; s++) begin : g_stage
    localparam int    SH  = hyp_iter(s);
    localparam word_t ANG = atanh_q(SH);
    vec_t nxt;
    logic up;

    always_comb begin
      up = (vec[s].z >= 0);
      if (up) begin
        nxt.x = vec[s].x + (vec[s].y >>> SH);
        nxt.y = vec[s].y + (vec[s].x >>> SH);
        nxt.z = vec[s].z - ANG;
      end else begin
        nxt.x = vec[s].x - (vec[s].y >>> SH);
        nxt.y = vec[s].y - (vec[s].x >>> SH);
        nxt.z = vec[s].z + ANG;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v[s+1] <= 1'b0;
      else        v[s+1] <= v[s];
    end

    always_ff @(posedge clk) begin
      if (v[s]) vec[s+1] <= nxt;
    end

    // R2
    stage_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      v[s+1] == $past(v[s]));
  end

  assign v_o  = v[NS];
  assign ch_o = vec[NS].x;
  assign sh_o = vec[NS].y;

  // R3
  cosh_dom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v[NS] |-> (vec[NS].x > vec[NS].y && vec[NS].x > -vec[NS].y));

  // R3
  angle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v[NS] |-> (vec[NS].z < ZRESB && vec[NS].z > -ZRESB));
endmodule

// File: rtl/sig_lin_div.sv
module sig_lin_div
  import sig_pkg::*;
#(
  parameter int N_ITER = 20
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  v_i,
  input  word_t num_i,
  input  word_t den_i,
  output logic  v_o,
  output word_t q_o
);
  localparam word_t ONE_Q = word_t'(1) <<< FR;

  logic v   [0:N_ITER];
  vec_t vec [0:N_ITER];

  assign v[0]   = v_i;
  assign vec[0] = '{x: den_i, y: num_i, z: '0};

  for (genvar s = 0; s < N_ITER; s++) begin : g_stage
    localparam word_t STEP = word_t'(1) <<< (FR - s);
    vec_t nxt;
    logic dn;

    always_comb begin
      dn    = (vec[s].y >= 0);
      nxt.x = vec[s].x;
      if (dn) begin
        nxt.y = vec[s].y - (vec[s].x >>> s);
        nxt.z = vec[s].z + STEP;
      end else begin
        nxt.y = vec[s].y + (vec[s].x >>> s);
        nxt.z = vec[s].z - STEP;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v[s+1] <= 1'b0;
      else        v[s+1] <= v[s];
    end

    always_ff @(posedge clk) begin
      if (v[s]) vec[s+1] <= nxt;
    end

    // R2
    stage_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      v[s+1] == $past(v[s]));
  end

  assign v_o = v[N_ITER];
  assign q_o = vec[N_ITER].z;

  // R3
  quot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v[N_ITER] |-> (vec[N_ITER].z < ONE_Q && vec[N_ITER].z > -ONE_Q));

  // R3
  div_resid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v[N_ITER] |-> (vec[N_ITER].y < (vec[N_ITER].x >>> (N_ITER - 2)) &&
                   vec[N_ITER].y > -(vec[N_ITER].x >>> (N_ITER - 2))));
endmodule

// File: rtl/sigmoid_cordic.sv
module sigmoid_cordic
  import sig_pkg::*;
#(
  parameter int ROT_ITERS = 18,
  parameter int DIV_ITERS = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic [OUT_W-1:0]        out_data
);
  localparam int    QSH  = FR - OUT_W + 1;
  localparam word_t RND  = word_t'(1) <<< (QSH - 1);
  localparam word_t HALF = word_t'(1) <<< (OUT_W - 1);

  logic  rst_meta, rst_sync_n;
  logic  s0_v;
  vec_t  s0_vec;
  logic  hr_v;
  word_t hr_ch, hr_sh;
  logic  dv_v;
  word_t dv_q;
  word_t code;
  logic  ov_q;
  logic [OUT_W-1:0] od_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  sig_in_stage u_in (
    .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .in_data(in_data),
    .v_o(s0_v), .vec_o(s0_vec)
  );

  sig_hyp_rot #(.N_ITER(ROT_ITERS)) u_rot (
    .clk(clk), .rst_n(rst_sync_n), .v_i(s0_v), .vec_i(s0_vec),
    .v_o(hr_v), .ch_o(hr_ch), .sh_o(hr_sh)
  );

  sig_lin_div #(.N_ITER(DIV_ITERS)) u_div (
    .clk(clk), .rst_n(rst_sync_n), .v_i(hr_v), .num_i(hr_sh), .den_i(hr_ch),
    .v_o(dv_v), .q_o(dv_q)
  );

  always_comb begin
    code = HALF + ((dv_q + RND) >>> QSH);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ov_q <= 1'b0;
      od_q <= '0;
    end else begin
      ov_q <= dv_v;
      if (dv_v) od_q <= code[OUT_W-1:0];
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;

  // R2
  out_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid == $past(dv_v));

  // R7
  map_nowrap_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dv_v |-> (code[DW-1:OUT_W] == '0));

  // R7
  out_range_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> (out_data >= 16'd17620 && out_data <= 16'd47915));
endmodule

// File: tb/sim_sigmoid_cordic.sv
`timescale 1ns/1ps
module sim_sigmoid_cordic;
  localparam int LAT = 42;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic [15:0] out_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bit qv[$];
  int qd[$];
  bit qm[$];

  int  out_p1 = -1, out_m1 = -1;
  int  prev_out = 0;
  bit  have_prev = 1'b0;
  real err_sum = 0.0;
  int  err_n = 0;

  always #2.5 clk = ~clk;

  sigmoid_cordic u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic real sig(real x);
    return 1.0 / (1.0 + $exp(-x));
  endfunction

  function automatic int clampv(int d);
    if (d > 16384) return 16384;
    if (d < -16384) return -16384;
    return d;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare();
    bit ev; int ed; bit em;
    int xs; int expc; int o; real ex;
    ev = qv.pop_front(); ed = qd.pop_front(); em = qm.pop_front();
    chk(out_valid == ev, "R2 valid timing", int'(out_valid), int'(ev));
    if (ev) begin
      o    = int'(out_data);
      xs   = clampv(ed);
      ex   = sig(real'(xs) / 16384.0);
      expc = $rtoi(ex * 65536.0 + 0.5);
      chk((o - expc) <= 2 && (expc - o) <= 2, "R3 accuracy", o, expc);
      chk(o >= 17620 && o <= 47915, "R7 range", o, 32768);
      if (xs == 0) chk(o == 32768, "R5 zero gives half", o, 32768);
      if (ed == 16384 && out_p1 < 0) out_p1 = o;
      if (ed == -16384 && out_m1 < 0) out_m1 = o;
      if (ed > 16384)  chk(o == out_p1, "R4 clamp high", o, out_p1);
      if (ed < -16384) chk(o == out_m1, "R4 clamp low", o, out_m1);
      if (em) begin
        if (have_prev) chk(o >= prev_out, "R6 monotonic", o, prev_out);
        prev_out  = o;
        have_prev = 1'b1;
        err_sum  += ((real'(o) / 65536.0) > ex) ? (real'(o) / 65536.0 - ex)
                                                : (ex - real'(o) / 65536.0);
        err_n++;
      end else have_prev = 1'b0;
    end
  endtask

  task automatic step(input bit v, input int d, input bit mono);
    @(negedge clk);
    compare();
    in_valid = v;
    in_data  = 16'(d);
    qv.push_back(v); qd.push_back(d); qm.push_back(mono);
  endtask

  task automatic drain();
    for (int k = 0; k < LAT + 2; k++) step(1'b0, 0, 1'b0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    // R1: outputs quiet during reset and the synchronizer delay
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(out_valid == 1'b0 && out_data == 16'd0, "R1 reset state",
          int'(out_data), 0);
    end
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(out_valid == 1'b0 && out_data == 16'd0, "R1 after release",
          int'(out_data), 0);
    end
    for (int k = 0; k < LAT; k++) begin
      qv.push_back(1'b0); qd.push_back(0); qm.push_back(1'b0);
    end
    // directed: boundaries first, then zero, then clamped operands (R4, R5)
    step(1'b1, 16384, 1'b0);
    step(1'b1, -16384, 1'b0);
    step(1'b1, 0, 1'b0);
    step(1'b0, 0, 1'b0);
    step(1'b1, 32767, 1'b0);
    step(1'b1, -32768, 1'b0);
    step(1'b1, 20000, 1'b0);
    step(1'b1, -16385, 1'b0);
    step(1'b1, 1, 1'b0);
    step(1'b1, -1, 1'b0);
    drain();
    // R6, R8: back-to-back increasing sweep
    for (int x = -16384; x <= 16384; x += 64) step(1'b1, x, 1'b1);
    drain();
    // R2, R3: random operands with random gaps
    for (int k = 0; k < 400; k++) begin
      int r;
      r = int'($urandom_range(0, 40000)) - 20000;
      step(1'($urandom_range(0, 1)), r, 1'b0);
    end
    drain();
    checks++;
    if (err_n == 0 || (err_sum / real'(err_n)) > 4.23e-4) begin
      failures++;
      $display("FAIL R8 mean error actual=%0d expected=%0d (1e-7 units)",
               (err_n == 0) ? -1 : $rtoi(1.0e7 * err_sum / real'(err_n)), 4230);
    end
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule